// File: doc/BRIEF.md
# Dual-Half Compare Counter/Timer

This block is one counter/timer pair built from two 16-bit halves, A and B. Each half counts up on the cycles where it is enabled and its tick input is high. Two compare values per half shape its output waveform in one of five modes: single count, repeated count, one-shot pulse, continuous pulse and free run. A link bit chains the halves into a single 32-bit counter that is governed by the half A controls.

Software configures the block through a plain synchronous register port. A write strobe with a 2-bit address and a 32-bit data word loads one register. Read data is a combinational function of the address. Each half drives one pin signal, which can be inverted or parked at a fixed level, and one single-cycle interrupt request.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset every register reads 0 and both pins and both interrupt requests are 0. The control word stores all 32 written bits and reads them back unchanged. Its half A fields are: enable at bit 0, clock select in bits 5:1 (stored only), function in bits 8:6, interrupt enable at bit 9, output enable at bit 10, clear at bit 11 and polarity at bit 12. Half B uses the same fields shifted up by 16, and link is bit 31.
- R2: Address 0 is the count register, with half B in bits 31:16 and half A in bits 15:0. Writing it loads both counters. Address 1 holds the half A compares and address 2 the half B compares, each with compare 0 in bits 15:0 and compare 1 in bits 31:16. Address 3 is the control word.
- R3: A half's count advances by one only on a clock edge where its enable bit is 1 and its own tick input is high. The two halves are gated independently.
- R4: While a half's clear bit is 1, its counter is held at 0 and its output at 0. Once clear returns to 0, counting resumes.
- R5: Function 0 counts up to compare 0. On the next advance the output toggles, and the counter then stays at compare 0 and the output keeps its new level.
- R6: Function 1 counts to compare 0. On the next advance it returns to 0 and raises the output for one advance, so the period is compare 0 + 1 advances.
- R7: Function 2 raises the output on the advance taken at compare 0 and drops it on the advance taken at compare 1. It then stops, holding the counter at compare 1.
- R8: Function 3 behaves like function 2, but the advance at compare 1 drops the output, restarts the count from 0, and the pattern repeats.
- R9: Function 4 counts continuously, wrapping from full scale (0xFFFF) to 0.
- R10: Function codes 5 to 7 hold the counter and force the timer output to 0.
- R11: With output enable 0 the pin equals the polarity bit. With output enable 1 the pin is the timer output XOR the polarity bit.
- R12: A half pulses its interrupt request for one cycle after each advance taken at compare 0, only if its interrupt enable bit is 1.
- R13: With link at 1 the halves form a 32-bit counter {B,A}, driven by half A's enable, tick, clear, function and output controls. Its compare 0 is {B compare 0, A compare 0} and its compare 1 is {B compare 1, A compare 1}. Half B's interrupt request stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_a | input | 1 | Count-enable tick for half A |
| tick_b | input | 1 | Count-enable tick for half B |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pin_a | output | 1 | Half A pin signal |
| pin_b | output | 1 | Half B pin signal |
| irq_a | output | 1 | Half A interrupt request pulse |
| irq_b | output | 1 | Half B interrupt request pulse |

## Verification
A wrong counter value shows up in the count register on the next read. It also moves every later compare event, so pulses on the pins and interrupt lines arrive at the wrong advance. A stale stop flag or output level shows up as a pin that holds, or fails to hold, its level over the following advances. It also shows up as a pulse count that differs from the expected count within one waveform period. A carry fault between the halves in linked mode shows up the first time the low half wraps.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_a,
  input  logic            tick_b,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [2*HW-1:0] wdata,
  output logic [2*HW-1:0] rdata,
  output logic            pin_a,
  output logic            pin_b,
  output logic            irq_a,
  output logic            irq_b
);
  localparam int DW     = 2 * HW;
  localparam int F_EN   = 0;
  localparam int F_FN   = 6;
  localparam int F_IE   = 9;
  localparam int F_OE   = 10;
  localparam int F_CLR  = 11;
  localparam int F_POL  = 12;
  localparam int F_LINK = DW - 1;
  localparam logic [1:0] A_CNT = 2'd0, A_CMPA = 2'd1, A_CMPB = 2'd2, A_CTRL = 2'd3;

  logic [DW-1:0] ctrl, cmp_a, cmp_b;
  logic [HW-1:0] cnt_a, cnt_b;
  logic          out_a, out_b, done_a, done_b;

  function automatic logic [DW+1:0] step(input logic [2:0] fn, input logic [DW-1:0] c,
                                         input logic [DW-1:0] c0, input logic [DW-1:0] c1,
                                         input logic [DW-1:0] mx, input logic o, input logic d);
    logic [DW-1:0] nc, inc;
    logic no, nd;
    inc = (c == mx) ? '0 : c + 1'b1;
    nc = c; no = o; nd = d;
    case (fn)
      3'd0: if (!d) begin
        if (c == c0) begin no = ~o; nd = 1'b1; end
        else nc = inc;
      end
      3'd1: if (c == c0) begin nc = '0; no = 1'b1; end
            else begin nc = inc; no = 1'b0; end
      3'd2: if (!d) begin
        if (c == c1) begin no = 1'b0; nd = 1'b1; end
        else begin if (c == c0) no = 1'b1; nc = inc; end
      end
      3'd3: if (c == c1) begin nc = '0; no = 1'b0; end
            else begin if (c == c0) no = 1'b1; nc = inc; end
      3'd4: begin nc = inc; no = 1'b0; end
      default: no = 1'b0;
    endcase
    return {nc, no, nd};
  endfunction

  logic          link, wr_cnt;
  logic [DW-1:0] a_c, a_c0, a_c1, a_mx, b_c, b_c0, b_c1, b_mx;
  logic [DW+1:0] nxt_a, nxt_b;
  logic          adv_a, adv_b, hit_a, hit_b;
  logic          unused_hi;

  assign link   = ctrl[F_LINK];
  assign wr_cnt = wr_en && addr == A_CNT;

  assign a_c  = link ? {cnt_b, cnt_a} : {{HW{1'b0}}, cnt_a};
  assign a_c0 = link ? {cmp_b[HW-1:0], cmp_a[HW-1:0]} : {{HW{1'b0}}, cmp_a[HW-1:0]};
  assign a_c1 = link ? {cmp_b[DW-1:HW], cmp_a[DW-1:HW]} : {{HW{1'b0}}, cmp_a[DW-1:HW]};
  assign a_mx = link ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
  assign b_c  = {{HW{1'b0}}, cnt_b};
  assign b_c0 = {{HW{1'b0}}, cmp_b[HW-1:0]};
  assign b_c1 = {{HW{1'b0}}, cmp_b[DW-1:HW]};
  assign b_mx = {{HW{1'b0}}, {HW{1'b1}}};

  assign adv_a = ctrl[F_EN] && tick_a && !ctrl[F_CLR];
  assign adv_b = !link && ctrl[HW+F_EN] && tick_b && !ctrl[HW+F_CLR];
  assign hit_a = a_c == a_c0;
  assign hit_b = b_c == b_c0;

  assign nxt_a = step(ctrl[F_FN+:3], a_c, a_c0, a_c1, a_mx, out_a, done_a);
  assign nxt_b = step(ctrl[HW+F_FN+:3], b_c, b_c0, b_c1, b_mx, out_b, done_b);
  assign unused_hi = ^nxt_b[DW+1:HW+2];

  assign pin_a = ctrl[F_OE] ? (out_a ^ ctrl[F_POL]) : ctrl[F_POL];
  assign pin_b = ctrl[HW+F_OE] ? (out_b ^ ctrl[HW+F_POL]) : ctrl[HW+F_POL];

  always_comb begin
    case (addr)
      A_CNT:   rdata = {cnt_b, cnt_a};
      A_CMPA:  rdata = cmp_a;
      A_CMPB:  rdata = cmp_b;
      default: rdata = ctrl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; cmp_a <= '0; cmp_b <= '0;
      cnt_a <= '0; cnt_b <= '0;
      out_a <= 1'b0; out_b <= 1'b0; done_a <= 1'b0; done_b <= 1'b0;
      irq_a <= 1'b0; irq_b <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl  <= wdata;
      if (wr_en && addr == A_CMPA) cmp_a <= wdata;
      if (wr_en && addr == A_CMPB) cmp_b <= wdata;
      irq_a <= adv_a && hit_a && ctrl[F_IE];
      irq_b <= adv_b && hit_b && ctrl[HW+F_IE];

      if (ctrl[F_CLR]) begin
        cnt_a <= '0; out_a <= 1'b0; done_a <= 1'b0;
      end else if (wr_cnt) begin
        cnt_a <= wdata[HW-1:0];
      end else if (adv_a) begin
        cnt_a  <= nxt_a[HW+1:2];
        out_a  <= nxt_a[1];
        done_a <= nxt_a[0];
      end

      if (link) begin
        out_b <= 1'b0; done_b <= 1'b0;
        if (ctrl[F_CLR])  cnt_b <= '0;
        else if (wr_cnt)  cnt_b <= wdata[DW-1:HW];
        else if (adv_a)   cnt_b <= nxt_a[DW+1:HW+2];
      end else if (ctrl[HW+F_CLR]) begin
        cnt_b <= '0; out_b <= 1'b0; done_b <= 1'b0;
      end else if (wr_cnt) begin
        cnt_b <= wdata[DW-1:HW];
      end else if (adv_b) begin
        cnt_b  <= nxt_b[HW+1:2];
        out_b  <= nxt_b[1];
        done_b <= nxt_b[0];
      end
    end
  end
endmodule

module dual_cmp_timer_chk #(
  parameter int HW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*HW-1:0] ctrl,
  input logic [HW-1:0]   cnt_a,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic            irq_a,
  input logic            irq_b
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[11] |=> cnt_a == '0); // R4
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[11] && !(wr_en && addr == 2'd0)) |=> $stable(cnt_a)); // R3
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[9] |=> !irq_a); // R12
  AST_LINKED_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2*HW-1] |=> !irq_b); // R13
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cnt_a(cnt_a),
  .wr_en(wr_en), .addr(addr), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick_a = 1'b0, tick_b = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic pin_a, pin_b, irq_a, irq_b;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dual_cmp_timer u0 (.clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_a(pin_a), .pin_b(pin_b), .irq_a(irq_a), .irq_b(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic go(input int n, input logic ta, input logic tb);
    @(negedge clk); tick_a = ta; tick_b = tb;
    repeat (n) @(posedge clk);
    @(negedge clk); tick_a = 1'b0; tick_b = 1'b0;
  endtask

  task automatic run_a(input int n, output int hp, output int hi);
    hp = 0; hi = 0;
    @(negedge clk); tick_a = 1'b1;
    repeat (n) begin
      @(posedge clk); #2;
      hp += int'(pin_a); hi += int'(irq_a);
    end
    @(negedge clk); tick_a = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin rd(2'(i), v); chk("R1 reset reg", v, 0); end
    chk("R1 reset pins/irqs", {28'd0, pin_a, pin_b, irq_a, irq_b}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd0, 32'hA5A5_5A5A); rd(2'd0, v); chk("R2 count load", v, 32'hA5A5_5A5A);
    wr(2'd1, 32'h1234_5678); rd(2'd1, v); chk("R2 compare A", v, 32'h1234_5678);
    wr(2'd2, 32'h9ABC_DEF0); rd(2'd2, v); chk("R2 compare B", v, 32'h9ABC_DEF0);
    wr(2'd3, 32'h7FFE_7FFE); rd(2'd3, v); chk("R1 control readback", v, 32'h7FFE_7FFE);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(2'd3, 32'h0800_0800); wr(2'd3, 32'h0101_0101);
    repeat (4) @(posedge clk);
    rd(2'd0, v); chk("R3 no tick no count", v, 0);
    go(5, 1'b1, 1'b0); rd(2'd0, v); chk("R3 tick_a only", v, 32'h0000_0005);
    go(3, 1'b0, 1'b1); rd(2'd0, v); chk("R3 tick_b only", v, 32'h0003_0005);
    wr(2'd3, 32'h0100_0100);
    go(4, 1'b1, 1'b1); rd(2'd0, v); chk("R3 disabled holds", v, 32'h0003_0005);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(2'd3, 32'h0000_0901);
    go(4, 1'b1, 1'b0); rd(2'd0, v); chk("R4 clear holds zero", v, 32'h0003_0000);
    wr(2'd3, 32'h0000_0101);
    go(3, 1'b1, 1'b0); rd(2'd0, v); chk("R4 resume after clear", v, 32'h0003_0003);
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(2'd1, 32'h0000_0004); wr(2'd3, 32'h800); wr(2'd3, 32'h401);
    go(4, 1'b1, 1'b0); rd(2'd0, v);
    chk("R5 reach compare", {v[15:0], 15'd0, pin_a}, {16'd4, 16'd0});
    go(1, 1'b1, 1'b0); chk("R5 toggle", {31'd0, pin_a}, 1);
    go(5, 1'b1, 1'b0); rd(2'd0, v);
    chk("R5 sticks and stops", {v[15:0], 15'd0, pin_a}, {16'd4, 16'd1});
  endtask

  task automatic t_pin();
    wr(2'd3, 32'h1401); chk("R11 inverted out", {31'd0, pin_a}, 0);
    wr(2'd3, 32'h1001); chk("R11 parked at pol 1", {31'd0, pin_a}, 1);
    wr(2'd3, 32'h0001); chk("R11 parked at pol 0", {31'd0, pin_a}, 0);
    wr(2'd3, 32'h0401); chk("R11 direct out", {31'd0, pin_a}, 1);
  endtask

  task automatic t_repeat();
    int hp, hi;
    wr(2'd1, 32'h0000_0003); wr(2'd3, 32'h800); wr(2'd3, 32'h641);
    run_a(12, hp, hi);
    chk("R6 pulse count", 32'(hp), 3);
    chk("R12 irq count enabled", 32'(hi), 3);
    wr(2'd3, 32'h800); wr(2'd3, 32'h441);
    run_a(12, hp, hi);
    chk("R12 irq masked", 32'(hi), 0);
  endtask

  task automatic t_oneshot();
    int hp, hi;
    logic [31:0] v;
    wr(2'd1, 32'h0005_0002); wr(2'd3, 32'h800); wr(2'd3, 32'h481);
    run_a(20, hp, hi);
    rd(2'd0, v);
    chk("R7 high cycles", 32'(hp), 3);
    chk("R7 stopped at compare 1", {v[15:0], 15'd0, pin_a}, {16'd5, 16'd0});
  endtask

  task automatic t_contpulse();
    int hp, hi;
    wr(2'd3, 32'h800); wr(2'd3, 32'h4C1);
    run_a(18, hp, hi);
    chk("R8 high cycles over 3 periods", 32'(hp), 9);
  endtask

  task automatic t_freerun();
    logic [31:0] v;
    wr(2'd3, 32'h100); wr(2'd0, 32'h0000_FFFD); wr(2'd3, 32'h101);
    go(2, 1'b1, 1'b0); rd(2'd0, v); chk("R9 full scale", v, 32'h0000_FFFF);
    go(1, 1'b1, 1'b0); rd(2'd0, v); chk("R9 wrap", v, 32'h0000_0000);
  endtask

  task automatic t_badfn();
    logic [31:0] v;
    wr(2'd3, 32'h540); wr(2'd0, 32'h0000_0007); wr(2'd3, 32'h541);
    go(5, 1'b1, 1'b0); rd(2'd0, v);
    chk("R10 code 5 holds", {v[15:0], 15'd0, pin_a}, {16'd7, 16'd0});
    wr(2'd3, 32'h5C1);
    go(3, 1'b1, 1'b0); rd(2'd0, v); chk("R10 code 7 holds", v, 32'h0000_0007);
  endtask

  task automatic t_link();
    logic [31:0] v;
    wr(2'd3, 32'h8000_0100); wr(2'd0, 32'h0000_FFFE); wr(2'd3, 32'h8000_0101);
    go(3, 1'b1, 1'b0); rd(2'd0, v); chk("R13 carry into B", v, 32'h0001_0001);
    wr(2'd1, 32'h0000_0002); wr(2'd2, 32'h0000_0001);
    wr(2'd3, 32'h8000_0800); wr(2'd3, 32'h8000_0400);
    wr(2'd0, 32'h0000_FFFF); wr(2'd3, 32'h8000_0401);
    go(3, 1'b1, 1'b0); rd(2'd0, v);
    chk("R13 32-bit count before match", {v, 31'd0, pin_a}, {32'h0001_0002, 32'd0});
    go(1, 1'b1, 1'b0); rd(2'd0, v);
    chk("R13 32-bit compare fires", {v, 31'd0, pin_a}, {32'h0001_0002, 32'd1});
  endtask

  logic finished = 1'b0;

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regs();
    wr(2'd3, 32'h0);
    t_gate();
    t_clear();
    t_single();
    t_pin();
    t_repeat();
    t_oneshot();
    t_contpulse();
    t_freerun();
    t_badfn();
    t_link();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule